// File: doc/BRIEF.md
# Frame-Buffered SPI Controller

This block is an SPI port that works either as bus master or as a selected slave. It uses a single fixed timing mode: data is sampled on the rising clock edge and changed on the falling edge, with the most significant bit first. A frame runs from the falling edge of the active-low select to its next rising edge. Two twelve-entry byte queues, one for transmit and one for receive, let a whole frame of up to twelve bytes pass without the host servicing the block in the middle of the frame.

The host loads transmit bytes through a write strobe and takes received bytes from a show-ahead read port. It sets enable, role, loopback and divider through plain control inputs and reads the queue levels, the frame-active flag and a sticky receive-overflow flag. In master mode a start pulse opens a frame. The block then generates the serial clock and the select itself. In slave mode the external clock and select pass through two-flop synchronisers and their edges are detected in the system clock domain. For testing, loopback sends the block's own outgoing bit back into its shift register, so transmit bytes arrive in the receive queue.

Top module: `spi_frame_ctrl`

## Requirements
- R1: After reset, ss_n_o is 1, sck_o, mosi_o and miso_o are 0, both levels are 0, rx_empty is 1, and frame_active and rx_overflow are 0.
- R2: Each queue holds 12 bytes. After 12 writes, tx_full is 1 and tx_level is 12. A write made while the transmit queue is full is dropped and never sent.
- R3: In master mode each byte appears on mosi_o MSB first. mosi_o changes only on a falling sck_o edge, so each bit is valid at the following rising edge.
- R4: In master mode (ctrl_div of 2 or more, loopback off), the bits on miso_i sampled at the rising sck_o edges form bytes that enter the receive queue in arrival order.
- R5: A master frame starts on a ctrl_start pulse when the transmit queue is not empty. It ends after the last queued byte: a frame carrying N bytes has exactly 8*N rising sck_o edges.
- R6: A master frame never carries more than 12 bytes. Bytes still queued after the twelfth stay in the transmit queue.
- R7: While ss_n_o is low, every sck_o level lasts exactly ctrl_div+1 clock cycles, counted from the falling edge of ss_n_o.
- R8: While ss_n_o is high, sck_o stays low.
- R9: With master loopback, the receive queue gets the transmitted bytes unchanged, whatever is on miso_i.
- R10: In slave mode, bytes sent on mosi_i under ss_n_i low enter the receive queue, and the queued transmit bytes appear on miso_o MSB first, one bit per sck_i cycle.
- R11: A selected slave whose transmit queue is empty sends 0x00.
- R12: A byte that completes while the receive queue is full is dropped and sets rx_overflow. rx_overflow stays set until a one is written on ovf_clr.
- R13: With slave loopback, the receive queue gets the transmit bytes that appear on miso_o, and mosi_i has no effect.
- R14: frame_active is 1 during a frame. While ctrl_enable is 0, ctrl_start opens no frame and leaves the transmit queue untouched.

Ports, in the order of the top module's port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_enable | input | 1 | Block enable |
| ctrl_master | input | 1 | 1 selects master, 0 selects slave |
| ctrl_loop | input | 1 | Internal loopback enable |
| ctrl_div | input | DIV_W | Half serial clock period minus one, in clocks |
| ctrl_start | input | 1 | Start pulse for a master frame |
| ovf_clr | input | 1 | Writing a one clears rx_overflow |
| tx_wr_en | input | 1 | Transmit queue write strobe |
| tx_wr_data | input | DATA_W | Transmit byte |
| tx_full | output | 1 | Transmit queue full |
| rx_rd_en | input | 1 | Receive queue read strobe |
| rx_rd_data | output | DATA_W | Oldest received byte (show-ahead) |
| rx_empty | output | 1 | Receive queue empty |
| tx_level | output | LVL_W | Transmit queue occupancy |
| rx_level | output | LVL_W | Receive queue occupancy |
| frame_active | output | 1 | A frame is in progress |
| rx_overflow | output | 1 | Sticky receive overflow |
| sck_i | input | 1 | Serial clock in (slave) |
| ss_n_i | input | 1 | Active-low select in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_i | input | 1 | Serial data in (master) |
| sck_o | output | 1 | Serial clock out (master) |
| ss_n_o | output | 1 | Active-low select out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_o | output | 1 | Serial data out (slave) |

## Verification
A bit counter that slips shows up at once at the ports: the serial clock edge count of the frame is no longer a multiple of eight, and the bytes collected from mosi_o are rotated, which the bench sees in the frame where the slip happens. A divider or phase error breaks the half-period length on the first clock edge after it, and the bench compares that length on every cycle. A frame limit, queue pointer or overflow flag that is wrong is seen once the frame ends, through the byte count, the order of the bytes read back from the queue, or a flag that does not set or does not hold until it is cleared.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_MASTER = 2'd1,
        MODE_SLAVE  = 2'd2
    } spi_mode_e;
endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = d;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{s1: RST_VAL, s2: RST_VAL};
        else        sync_q <= sync_d;
    end

    assign q = sync_q.s2;
endmodule

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [LVL_W-1:0]        cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full     = (fifo_q.cnt == LVL_W'(DEPTH));
    assign empty    = (fifo_q.cnt == '0);
    assign level    = fifo_q.cnt;
    assign pop_data = fifo_q.mem[fifo_q.rp];

    always_comb begin
        fifo_d  = fifo_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            fifo_d.mem[fifo_q.wp] = push_data;
            fifo_d.wp             = ptr_inc(fifo_q.wp);
        end
        if (do_pop) fifo_d.rp = ptr_inc(fifo_q.rp);
        case ({do_push, do_pop})
            2'b10:   fifo_d.cnt = fifo_q.cnt + LVL_W'(1);
            2'b01:   fifo_d.cnt = fifo_q.cnt - LVL_W'(1);
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    // R2: occupancy never passes the depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R2: a write into a full queue leaves the level unchanged
    p_full_write_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(level));
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_frame_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 12,
    parameter int DIV_W  = 8,
    localparam int BIT_W = $clog2(DATA_W + 1),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              master,
    input  logic              loop,
    input  logic [DIV_W-1:0]  div,
    input  logic              start,
    input  logic              ovf_clr,
    input  logic              sck_s,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic              miso_s,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              mosi_o,
    output logic              miso_o,
    output logic              frame_active,
    output logic              overflow
);
    typedef struct packed {
        spi_mode_e         mode;
        logic [DATA_W-1:0] sh;
        logic              smp;
        logic [BIT_W-1:0]  bitc;
        logic [CNT_W-1:0]  bytec;
        logic [DIV_W-1:0]  divc;
        logic              sck;
        logic              ssn;
        logic              ovf;
        logic              sck_prev;
        logic              ss_prev;
    } eng_t;

    localparam eng_t ENG_RST = '{mode: MODE_IDLE, sh: '0, smp: 1'b0, bitc: '0,
                                 bytec: '0, divc: '0, sck: 1'b0, ssn: 1'b1,
                                 ovf: 1'b0, sck_prev: 1'b0, ss_prev: 1'b1};

    eng_t eng_d, eng_q;
    logic rx_in;
    logic [DATA_W-1:0] rx_word;

    always_comb begin
        eng_d   = eng_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_in   = loop ? eng_q.sh[DATA_W-1]
                       : ((eng_q.mode == MODE_MASTER) ? miso_s : mosi_s);
        rx_word = {eng_q.sh[DATA_W-2:0], rx_in};
        eng_d.sck_prev = sck_s;
        eng_d.ss_prev  = ss_n_s;
        if (ovf_clr) eng_d.ovf = 1'b0;

        unique case (eng_q.mode)
            MODE_IDLE: begin
                eng_d.sck = 1'b0;
                eng_d.ssn = 1'b1;
                if (enable && master && start && !tx_empty) begin
                    eng_d.mode  = MODE_MASTER;
                    eng_d.ssn   = 1'b0;
                    eng_d.sh    = tx_data;
                    tx_pop      = 1'b1;
                    eng_d.bitc  = '0;
                    eng_d.bytec = '0;
                    eng_d.divc  = '0;
                end else if (enable && !master && eng_q.ss_prev && !ss_n_s) begin
                    eng_d.mode = MODE_SLAVE;
                    eng_d.sh   = tx_empty ? '0 : tx_data;
                    tx_pop     = !tx_empty;
                    eng_d.bitc = '0;
                end
            end
            MODE_MASTER: begin
                if (!enable || !master) begin
                    eng_d.mode = MODE_IDLE;
                    eng_d.ssn  = 1'b1;
                    eng_d.sck  = 1'b0;
                end else if (eng_q.divc == div) begin
                    eng_d.divc = '0;
                    eng_d.sck  = !eng_q.sck;
                    if (!eng_q.sck) begin
                        eng_d.smp  = rx_in;
                        eng_d.bitc = eng_q.bitc + BIT_W'(1);
                        if (eng_q.bitc == BIT_W'(DATA_W - 1)) begin
                            rx_push     = 1'b1;
                            eng_d.bytec = eng_q.bytec + CNT_W'(1);
                        end
                    end else if (eng_q.bitc == BIT_W'(DATA_W)) begin
                        if (!tx_empty && eng_q.bytec < CNT_W'(DEPTH)) begin
                            eng_d.sh   = tx_data;
                            tx_pop     = 1'b1;
                            eng_d.bitc = '0;
                        end else begin
                            eng_d.mode = MODE_IDLE;
                            eng_d.ssn  = 1'b1;
                        end
                    end else begin
                        eng_d.sh = {eng_q.sh[DATA_W-2:0], eng_q.smp};
                    end
                end else begin
                    eng_d.divc = eng_q.divc + DIV_W'(1);
                end
            end
            MODE_SLAVE: begin
                if (!enable || master || ss_n_s) begin
                    eng_d.mode = MODE_IDLE;
                end else if (!eng_q.sck_prev && sck_s) begin
                    eng_d.smp  = rx_in;
                    eng_d.bitc = eng_q.bitc + BIT_W'(1);
                    if (eng_q.bitc == BIT_W'(DATA_W - 1)) rx_push = 1'b1;
                end else if (eng_q.sck_prev && !sck_s) begin
                    if (eng_q.bitc == BIT_W'(DATA_W)) begin
                        eng_d.sh   = tx_empty ? '0 : tx_data;
                        tx_pop     = !tx_empty;
                        eng_d.bitc = '0;
                    end else begin
                        eng_d.sh = {eng_q.sh[DATA_W-2:0], eng_q.smp};
                    end
                end
            end
            default: eng_d.mode = MODE_IDLE;
        endcase

        if (rx_push && rx_full) eng_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign rx_data      = rx_word;
    assign sck_o        = eng_q.sck;
    assign ss_n_o       = eng_q.ssn;
    assign mosi_o       = (eng_q.mode == MODE_MASTER) ? eng_q.sh[DATA_W-1] : 1'b0;
    assign miso_o       = (eng_q.mode == MODE_SLAVE)  ? eng_q.sh[DATA_W-1] : 1'b0;
    assign frame_active = (eng_q.mode != MODE_IDLE);
    assign overflow     = eng_q.ovf;

    // R8: no clock activity while deselected
    p_sck_low_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sck_o);

    // R2: the transmit queue is only popped when it holds data
    p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);

    // R12: overflow holds until cleared
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);

    // R6: no further byte is fetched once a master frame carries its limit
    p_frame_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mode == MODE_MASTER && eng_q.bytec == CNT_W'(DEPTH)) |-> !tx_pop);

    // R7: the clock level is held until the divider expires
    p_sck_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mode == MODE_MASTER && enable && master && eng_q.divc != div)
        |=> $stable(sck_o));
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 12,
    parameter int DIV_W  = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_enable,
    input  logic              ctrl_master,
    input  logic              ctrl_loop,
    input  logic [DIV_W-1:0]  ctrl_div,
    input  logic              ctrl_start,
    input  logic              ovf_clr,
    input  logic              tx_wr_en,
    input  logic [DATA_W-1:0] tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd_en,
    output logic [DATA_W-1:0] rx_rd_data,
    output logic              rx_empty,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              frame_active,
    output logic              rx_overflow,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              mosi_o,
    output logic              miso_o
);
    logic [3:0]        pins_s;
    logic              tx_empty, tx_pop, rx_full, rx_push;
    logic [DATA_W-1:0] tx_data, rx_data;

    spi_sync2 #(.W(4), .RST_VAL(4'b1000)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_i, sck_i, mosi_i, miso_i}),
        .q     (pins_s)
    );

    spi_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_wr_en),
        .push_data (tx_wr_data),
        .pop       (tx_pop),
        .pop_data  (tx_data),
        .level     (tx_level),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_byte_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_rd_en),
        .pop_data  (rx_rd_data),
        .level     (rx_level),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spi_frame_engine #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (ctrl_enable),
        .master       (ctrl_master),
        .loop         (ctrl_loop),
        .div          (ctrl_div),
        .start        (ctrl_start),
        .ovf_clr      (ovf_clr),
        .sck_s        (pins_s[2]),
        .ss_n_s       (pins_s[3]),
        .mosi_s       (pins_s[1]),
        .miso_s       (pins_s[0]),
        .tx_empty     (tx_empty),
        .tx_data      (tx_data),
        .tx_pop       (tx_pop),
        .rx_full      (rx_full),
        .rx_push      (rx_push),
        .rx_data      (rx_data),
        .sck_o        (sck_o),
        .ss_n_o       (ss_n_o),
        .mosi_o       (mosi_o),
        .miso_o       (miso_o),
        .frame_active (frame_active),
        .overflow     (rx_overflow)
    );
endmodule

// File: tb/sim_spi_frame_ctrl.sv
module sim_spi_frame_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_enable = 1'b0, ctrl_master = 1'b0, ctrl_loop = 1'b0;
    logic [7:0] ctrl_div = 8'd3;
    logic       ctrl_start = 1'b0, ovf_clr = 1'b0;
    logic       tx_wr_en = 1'b0;
    logic [7:0] tx_wr_data = 8'h00;
    logic       tx_full, rx_empty, frame_active, rx_overflow;
    logic       rx_rd_en = 1'b0;
    logic [7:0] rx_rd_data;
    logic [3:0] tx_level, rx_level;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0, miso_i = 1'b0;
    logic       sck_o, ss_n_o, mosi_o, miso_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_frame_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .ctrl_master(ctrl_master),
        .ctrl_loop(ctrl_loop), .ctrl_div(ctrl_div), .ctrl_start(ctrl_start), .ovf_clr(ovf_clr),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .tx_level(tx_level), .rx_level(rx_level), .frame_active(frame_active),
        .rx_overflow(rx_overflow), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .miso_i(miso_i), .sck_o(sck_o), .ss_n_o(ss_n_o), .mosi_o(mosi_o), .miso_o(miso_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model of the far side of the master bus, checked every clock
    logic [7:0] mon_q[$];
    logic [7:0] slv_q[$];
    logic       prev_sck = 1'b0, prev_ssn = 1'b1;
    int         gap = 0, rises = 0, last_rises = 0, mbits = 0, sidx = 7;
    logic [7:0] mbyte = 8'h00, scur = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(!(ss_n_o && sck_o), "R8 sck low while deselected", sck_o, 0);
            if (prev_ssn && !ss_n_o) begin
                gap = 0; rises = 0; mbits = 0; sidx = 7;
                scur = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
                miso_i = scur[7];
            end else if (!prev_ssn) begin
                if (sck_o != prev_sck) begin
                    chk(gap + 1 == int'(ctrl_div) + 1, "R7 half period", gap + 1, int'(ctrl_div) + 1);
                    gap = 0;
                    if (sck_o) begin
                        rises++;
                        mbyte = {mbyte[6:0], mosi_o};
                        mbits++;
                        if (mbits == 8) begin mon_q.push_back(mbyte); mbits = 0; end
                    end else if (!ss_n_o) begin
                        sidx--;
                        if (sidx < 0) begin
                            scur = (slv_q.size() > 0) ? slv_q.pop_front() : 8'h00;
                            sidx = 7;
                        end
                        miso_i = scur[sidx];
                    end
                end else begin
                    gap++;
                end
                if (ss_n_o) last_rises = rises;
            end
            prev_sck = sck_o;
            prev_ssn = ss_n_o;
        end
    end

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); tx_wr_en = 1'b1; tx_wr_data = b;
        @(negedge clk); tx_wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(!rx_empty, req, rx_empty, 0);
        chk(rx_rd_data == exp, req, rx_rd_data, exp);
        rx_rd_en = 1'b1;
        @(negedge clk); rx_rd_en = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk); ctrl_start = 1'b1;
        @(negedge clk); ctrl_start = 1'b0;
    endtask

    task automatic wait_frame_end(input string req);
        int t = 0;
        chk(frame_active == 1'b1, req, frame_active, 1);
        while (frame_active && t < 20000) begin @(negedge clk); t++; end
        chk(frame_active == 1'b0, req, frame_active, 0);
        repeat (2) @(negedge clk);
    endtask

    // Bench acting as bus master for slave-mode tests
    logic [7:0] bm_tx[$];
    logic [7:0] bm_got[$];

    task automatic drive_slave_frame();
        logic [7:0] cap;
        bm_got.delete();
        @(negedge clk); ss_n_i = 1'b0;
        repeat (8) @(negedge clk);
        foreach (bm_tx[k]) begin
            cap = 8'h00;
            for (int b = 7; b >= 0; b--) begin
                mosi_i = bm_tx[k][b];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], miso_o};
                sck_i = 1'b1;
                repeat (8) @(negedge clk);
                sck_i = 1'b0;
            end
            bm_got.push_back(cap);
        end
        repeat (8) @(negedge clk);
        ss_n_i = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(ss_n_o == 1'b1, "R1 ss_n_o", ss_n_o, 1);
        chk(sck_o == 1'b0 && mosi_o == 1'b0 && miso_o == 1'b0, "R1 serial outs", {sck_o, mosi_o, miso_o}, 0);
        chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
        chk(rx_empty == 1'b1, "R1 rx_empty", rx_empty, 1);
        chk(frame_active == 1'b0 && rx_overflow == 1'b0, "R1 flags", {frame_active, rx_overflow}, 0);

        ctrl_enable = 1'b1; ctrl_master = 1'b1; ctrl_div = 8'd3;
        // R2
        for (int i = 0; i < 12; i++) host_write(8'hA0 + 8'(i));
        @(negedge clk);
        chk(tx_full == 1'b1, "R2 full after 12", tx_full, 1);
        chk(tx_level == 12, "R2 level 12", tx_level, 12);
        host_write(8'hEE);
        @(negedge clk);
        chk(tx_level == 12, "R2 write to full dropped", tx_level, 12);

        // R6, R3, R4: twelve-byte frame with extra bytes queued mid-frame
        for (int i = 0; i < 12; i++) slv_q.push_back(8'h30 + 8'(i));
        mon_q.delete();
        start_frame();
        begin
            int t = 0;
            while (rises < 20 && t < 5000) begin @(negedge clk); t++; end
        end
        host_write(8'hCC);
        host_write(8'hDD);
        wait_frame_end("R14 master frame active");
        chk(last_rises == 96, "R6 twelve-byte cap", last_rises, 96);
        chk(mon_q.size() == 12, "R3 byte count", mon_q.size(), 12);
        for (int i = 0; i < 12 && i < mon_q.size(); i++)
            chk(mon_q[i] == 8'hA0 + 8'(i), "R3 mosi byte", mon_q[i], 8'hA0 + 8'(i));
        chk(tx_level == 2, "R6 leftover stays queued", tx_level, 2);
        chk(rx_level == 12, "R4 rx level", rx_level, 12);
        for (int i = 0; i < 12; i++) host_read(8'h30 + 8'(i), "R4 miso byte");

        // R5, R7 with another divider
        ctrl_div = 8'd5;
        slv_q.delete(); slv_q.push_back(8'h5A); slv_q.push_back(8'hC3);
        mon_q.delete();
        start_frame();
        wait_frame_end("R14 master frame active");
        chk(last_rises == 16, "R5 ends after last byte", last_rises, 16);
        chk(mon_q.size() == 2 && mon_q[0] == 8'hCC && mon_q[1] == 8'hDD, "R3 queued bytes",
            (mon_q.size() == 2) ? {mon_q[0], mon_q[1]} : 0, 16'hCCDD);
        chk(tx_level == 0, "R5 tx drained", tx_level, 0);
        host_read(8'h5A, "R4 byte 0");
        host_read(8'hC3, "R4 byte 1");

        // R9 master loopback
        ctrl_loop = 1'b1; ctrl_div = 8'd2;
        slv_q.delete(); for (int i = 0; i < 3; i++) slv_q.push_back(8'hFF);
        mon_q.delete();
        host_write(8'h81); host_write(8'h7E); host_write(8'h55);
        start_frame();
        wait_frame_end("R14 master frame active");
        chk(last_rises == 24, "R5 three-byte frame", last_rises, 24);
        host_read(8'h81, "R9 loopback byte 0");
        host_read(8'h7E, "R9 loopback byte 1");
        host_read(8'h55, "R9 loopback byte 2");
        chk(mon_q.size() == 3, "R9 bytes on mosi", mon_q.size(), 3);

        // R12 overflow
        slv_q.delete();
        for (int i = 0; i < 12; i++) host_write(8'(i * 7 + 1));
        start_frame();
        wait_frame_end("R14 master frame active");
        chk(rx_level == 12 && rx_overflow == 1'b0, "R12 full, no overflow", {rx_level, rx_overflow}, 8'h18);
        host_write(8'h99);
        start_frame();
        wait_frame_end("R14 master frame active");
        chk(rx_overflow == 1'b1, "R12 overflow set", rx_overflow, 1);
        chk(rx_level == 12, "R12 level unchanged", rx_level, 12);
        repeat (10) @(negedge clk);
        chk(rx_overflow == 1'b1, "R12 overflow sticky", rx_overflow, 1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
        chk(rx_overflow == 1'b0, "R12 cleared by write", rx_overflow, 0);
        for (int i = 0; i < 12; i++) host_read(8'(i * 7 + 1), "R12 kept bytes");
        chk(rx_empty == 1'b1, "R12 dropped byte absent", rx_empty, 1);

        // R10, R11 slave
        ctrl_master = 1'b0; ctrl_loop = 1'b0;
        host_write(8'h3C); host_write(8'hA5);
        bm_tx.delete(); bm_tx.push_back(8'h11); bm_tx.push_back(8'h22); bm_tx.push_back(8'h33);
        drive_slave_frame();
        chk(bm_got.size() == 3, "R10 slave bytes", bm_got.size(), 3);
        if (bm_got.size() == 3) begin
            chk(bm_got[0] == 8'h3C, "R10 miso byte 0", bm_got[0], 8'h3C);
            chk(bm_got[1] == 8'hA5, "R10 miso byte 1", bm_got[1], 8'hA5);
            chk(bm_got[2] == 8'h00, "R11 empty queue sends zero", bm_got[2], 8'h00);
        end
        host_read(8'h11, "R10 mosi byte 0");
        host_read(8'h22, "R10 mosi byte 1");
        host_read(8'h33, "R10 mosi byte 2");
        chk(tx_level == 0, "R10 tx drained", tx_level, 0);

        // R13 slave loopback
        ctrl_loop = 1'b1;
        host_write(8'h6B); host_write(8'h94);
        bm_tx.delete(); bm_tx.push_back(8'hFF); bm_tx.push_back(8'hFF);
        drive_slave_frame();
        chk(bm_got.size() == 2 && bm_got[0] == 8'h6B && bm_got[1] == 8'h94, "R13 miso bytes",
            (bm_got.size() == 2) ? {bm_got[0], bm_got[1]} : 0, 16'h6B94);
        host_read(8'h6B, "R13 looped byte 0");
        host_read(8'h94, "R13 looped byte 1");
        chk(rx_empty == 1'b1, "R13 mosi ignored", rx_empty, 1);

        // R14 enable gating
        ctrl_master = 1'b1; ctrl_loop = 1'b0; ctrl_enable = 1'b0; ctrl_div = 8'd3;
        slv_q.delete(); mon_q.delete();
        host_write(8'h42);
        start_frame();
        repeat (30) @(negedge clk);
        chk(frame_active == 1'b0 && ss_n_o == 1'b1, "R14 disabled no frame", frame_active, 0);
        chk(tx_level == 1, "R14 queue untouched", tx_level, 1);
        ctrl_enable = 1'b1;
        start_frame();
        wait_frame_end("R14 frame after enable");
        chk(mon_q.size() == 1 && mon_q[0] == 8'h42, "R3 single byte",
            (mon_q.size() == 1) ? mon_q[0] : 0, 8'h42);
        host_read(8'h00, "R4 idle miso byte");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule